// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Subtract/Multiply Unit

This unit sits on the result path of a 64-bit integer datapath. It performs floating-point addition, subtraction and multiplication on the binary32 operands carried in the low bits of the two source buses. Each operation comes with a 5-bit operation code. Three codes select the floating-point operations. Any other code is consumed and produces no result. The result is registered and returned on a result bus of the full datapath width, with the bits above the floating-point word cleared.

The significand sum goes through a parallel-prefix carry-lookahead adder. The significand product comes from an array of carry-save adder rows that ends in the same lookahead adder. Both paths round to nearest, ties to even, with guard, round and sticky bits. Subnormal operands are taken as zeros of the same sign. Results that fall below the normal range become signed zeros. Every NaN result uses a single canonical quiet encoding.

Operands enter on a valid/ready handshake and the result leaves on a second one. A beat is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output register is empty, or is being emptied in that cycle (`out_ready` high). A result is presented until the cycle in which `out_valid` and `out_ready` are both high. While the downstream side stalls, the unit accepts nothing and holds its output unchanged.

Top module: `fp_unit`

## Requirements
- R1: Operation code 5'b00101 gives src1 + src2, 5'b00110 gives src1 − src2, and 5'b00111 gives src1 × src2. The operands are bits [FW-1:0] of each source bus, where FW = 1 + EXP_W + MAN_W and the layout is {sign, biased exponent, fraction}.
- R2: The result occupies out_result[FW-1:0]. Bits above FW are zero whatever the upper source bits hold.
- R3: For finite normal operands, the result is the exact sum, difference or product rounded to nearest with ties to even.
- R4: Any NaN operand gives the canonical quiet NaN: sign 0, exponent all ones, fraction MSB 1 and all other fraction bits 0 (0x7FC00000 for the default format).
- R5: Adding infinities of opposite effective sign, and multiplying zero by infinity, both give the canonical quiet NaN.
- R6: A rounded result whose exponent reaches the all-ones code becomes infinity with the correct sign. An infinite operand in an otherwise valid operation gives a signed infinity.
- R7: An operand with a zero exponent field counts as a zero of its sign. A rounded result below the smallest normal exponent becomes a zero of the result's sign. Zero times a finite value is a zero whose sign is the XOR of the operand signs.
- R8: An add or subtract whose exact result is zero gives +0, except that two zeros of the same negative sign give −0.
- R9: in_ready equals !out_valid || out_ready. A floating-point beat accepted at an edge appears with out_valid high right after that edge.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_result does not change.
- R11: A beat accepted with any other operation code is consumed and leaves out_valid low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_opcode | input | 5 | Operation code |
| in_src1 | input | XLEN | First source bus (A side) |
| in_src2 | input | XLEN | Second source bus (B side) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | XLEN | Zero-extended floating-point result |

## Verification
The bench builds the unit with XLEN = 16, EXP_W = 4 and MAN_W = 3. This is an 8-bit floating-point word with bias 7 and canonical NaN 0x7C, and it uses the same datapath code as the default binary32 build. At this size the bench sweeps every one of the 65,536 operand pairs for addition and for multiplication, and every fourth pair for subtraction. Each result is compared with a reference computed in real arithmetic, where every sum and product of this format is exact. The sweep therefore covers every tie, every rounding carry into the exponent, every cancellation depth, every overflow and underflow boundary and every special-value pairing. Short directed sequences cover stalls, non-floating-point codes and reset.

// File: rtl/fpu_pkg.sv
package fpu_pkg;

  typedef enum logic [4:0] {
    OPC_FADD = 5'b00101,
    OPC_FSUB = 5'b00110,
    OPC_FMUL = 5'b00111
  } fp_opc_e;

endpackage

// File: rtl/cla_add.sv
// Parallel-prefix (recursive doubling) carry-lookahead adder.
module cla_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int LG = (W > 1) ? $clog2(W) : 1;

  for (genvar k = 0; k <= LG; k++) begin : lv
    logic [W-1:0] g;
    logic [W-1:0] p;
    if (k == 0) begin : base
      assign g = a & b;
      assign p = a ^ b;
    end else begin : step
      localparam int D = 1 << (k - 1);
      for (genvar i = 0; i < W; i++) begin : col
        if (i >= D) begin : mrg
          assign g[i] = lv[k-1].g[i] | (lv[k-1].p[i] & lv[k-1].g[i-D]);
          assign p[i] = lv[k-1].p[i] & lv[k-1].p[i-D];
        end else begin : pas
          assign g[i] = lv[k-1].g[i];
          assign p[i] = lv[k-1].p[i];
        end
      end
    end
  end

  logic [W-1:0] cv;
  assign cv[0]     = cin;
  assign cv[W-1:1] = lv[LG].g[W-2:0] | (lv[LG].p[W-2:0] & {(W-1){cin}});
  assign sum       = lv[0].p ^ cv;
  assign cout      = lv[LG].g[W-1] | (lv[LG].p[W-1] & cin);

endmodule

// File: rtl/csa_mult.sv
// Unsigned multiplier: carry-save adder rows, final lookahead add.
module csa_mult #(
  parameter int N = 4
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] prod
);
  localparam int PW = 2 * N;

  for (genvar i = 0; i < N; i++) begin : rw
    logic [PW-1:0] pp;
    logic [PW-1:0] s;
    logic [PW-1:0] c;
    assign pp = b[i] ? (PW'(a) << i) : '0;
    if (i == 0) begin : first
      assign s = pp;
      assign c = '0;
    end else begin : fold
      assign s = rw[i-1].s ^ rw[i-1].c ^ pp;
      assign c = ((rw[i-1].s & rw[i-1].c) | (rw[i-1].s & pp) |
                  (rw[i-1].c & pp)) << 1;
    end
  end

  logic cout_unused;

  cla_add #(.W(PW)) u_final (
    .a   (rw[N-1].s),
    .b   (rw[N-1].c),
    .cin (1'b0),
    .sum (prod),
    .cout(cout_unused)
  );

endmodule

// File: rtl/fp_round.sv
// Round to nearest even, then range check and pack.
module fp_round #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int EW    = 15,
  parameter int FW    = 1 + EXP_W + MAN_W
) (
  input  logic                 sign,
  input  logic signed [EW-1:0] exp_in,
  input  logic [MAN_W:0]       sig_in,
  input  logic                 guard,
  input  logic                 sticky,
  output logic [FW-1:0]        res
);
  localparam logic signed [EW-1:0] EMAX_S = EW'((1 << EXP_W) - 1);

  logic                 inc;
  logic [MAN_W+1:0]     sum;
  logic [MAN_W-1:0]     man;
  logic signed [EW-1:0] exp_r;

  always_comb begin
    inc = guard & (sticky | sig_in[0]);
    sum = {1'b0, sig_in} + (MAN_W+2)'(inc);
    if (sum[MAN_W+1]) begin
      man   = sum[MAN_W:1];
      exp_r = exp_in + EW'(1);
    end else begin
      man   = sum[MAN_W-1:0];
      exp_r = exp_in;
    end
    if (exp_r >= EMAX_S)
      res = {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else if (exp_r <= 0)
      res = {sign, {(FW-1){1'b0}}};
    else
      res = {sign, exp_r[EXP_W-1:0], man};
  end

endmodule

// File: rtl/fp_add_core.sv
// Floating-point add/subtract: swap, align with sticky, CLA, normalize.
module fp_add_core #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int EW    = 15,
  parameter int FW    = 1 + EXP_W + MAN_W
) (
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] b,
  input  logic          sub,
  output logic [FW-1:0] res
);
  localparam int EXT = MAN_W + 4;
  localparam logic [EXP_W-1:0] EALL = '1;
  localparam logic [FW-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic sa, sb;
  logic [EXP_W-1:0] ea, eb;
  logic [MAN_W-1:0] ma, mb;
  logic nan_a, nan_b, inf_a, inf_b, zero_a, zero_b;

  assign sa = a[FW-1];
  assign sb = b[FW-1] ^ sub;
  assign ea = a[FW-2:MAN_W];
  assign eb = b[FW-2:MAN_W];
  assign ma = a[MAN_W-1:0];
  assign mb = b[MAN_W-1:0];
  assign nan_a  = (ea == EALL) && (ma != '0);
  assign nan_b  = (eb == EALL) && (mb != '0);
  assign inf_a  = (ea == EALL) && (ma == '0);
  assign inf_b  = (eb == EALL) && (mb == '0);
  assign zero_a = (ea == '0);
  assign zero_b = (eb == '0);

  logic             sl, ss, eff_sub;
  logic [EXP_W-1:0] el, es, diff;
  logic [EXT-1:0]   sig_l, sig_s, shifted, al_s;
  logic             lost;

  always_comb begin
    if (a[FW-2:0] >= b[FW-2:0]) begin
      sl = sa; el = ea; sig_l = zero_a ? '0 : {1'b1, ma, 3'b000};
      ss = sb; es = eb; sig_s = zero_b ? '0 : {1'b1, mb, 3'b000};
    end else begin
      sl = sb; el = eb; sig_l = zero_b ? '0 : {1'b1, mb, 3'b000};
      ss = sa; es = ea; sig_s = zero_a ? '0 : {1'b1, ma, 3'b000};
    end
    diff    = el - es;
    shifted = sig_s >> diff;
    lost    = |(sig_s & ~({EXT{1'b1}} << diff));
    al_s    = {shifted[EXT-1:1], shifted[0] | lost};
    eff_sub = sl ^ ss;
  end

  logic [EXT:0] opb, raw;
  logic         cout_unused;
  assign opb = eff_sub ? ~{1'b0, al_s} : {1'b0, al_s};

  cla_add #(.W(EXT+1)) u_sig_add (
    .a   ({1'b0, sig_l}),
    .b   (opb),
    .cin (eff_sub),
    .sum (raw),
    .cout(cout_unused)
  );

  // effective subtraction of the smaller magnitude never borrows
  always_comb begin
    if (eff_sub) begin
      a_no_borrow_r3: assert (raw[EXT] == 1'b0);
    end
  end

  logic [EXT-1:0]       norm;
  logic signed [EW-1:0] exp_n;
  int                   msb;

  always_comb begin
    msb = 0;
    for (int i = 0; i <= EXT; i++)
      if (raw[i]) msb = i;
    if (raw[EXT]) begin
      norm  = {raw[EXT:2], raw[1] | raw[0]};
      exp_n = EW'(el) + EW'(1);
    end else begin
      norm  = raw[EXT-1:0] << (EXT - 1 - msb);
      exp_n = EW'(el) - EW'(EXT - 1 - msb);
    end
  end

  logic [FW-1:0] rnd_res;

  fp_round #(.EXP_W(EXP_W), .MAN_W(MAN_W), .EW(EW)) u_rnd (
    .sign  (sl),
    .exp_in(exp_n),
    .sig_in(norm[EXT-1:3]),
    .guard (norm[2]),
    .sticky(norm[1] | norm[0]),
    .res   (rnd_res)
  );

  always_comb begin
    if (nan_a || nan_b)
      res = QNAN;
    else if (inf_a && inf_b)
      res = (sa != sb) ? QNAN : {sa, EALL, {MAN_W{1'b0}}};
    else if (inf_a)
      res = {sa, EALL, {MAN_W{1'b0}}};
    else if (inf_b)
      res = {sb, EALL, {MAN_W{1'b0}}};
    else if (zero_a && zero_b)
      res = {sa & sb, {(FW-1){1'b0}}};
    else if (raw == '0)
      res = '0;
    else
      res = rnd_res;
  end

endmodule

// File: rtl/fp_mul_core.sv
// Floating-point multiply: carry-save significand product, normalize, round.
module fp_mul_core #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int EW    = 15,
  parameter int FW    = 1 + EXP_W + MAN_W
) (
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] b,
  output logic [FW-1:0] res
);
  localparam int N    = MAN_W + 1;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] EALL = '1;
  localparam logic [FW-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic sp;
  logic [EXP_W-1:0] ea, eb;
  logic [MAN_W-1:0] ma, mb;
  logic nan_a, nan_b, inf_a, inf_b, zero_a, zero_b;

  assign sp = a[FW-1] ^ b[FW-1];
  assign ea = a[FW-2:MAN_W];
  assign eb = b[FW-2:MAN_W];
  assign ma = a[MAN_W-1:0];
  assign mb = b[MAN_W-1:0];
  assign nan_a  = (ea == EALL) && (ma != '0);
  assign nan_b  = (eb == EALL) && (mb != '0);
  assign inf_a  = (ea == EALL) && (ma == '0);
  assign inf_b  = (eb == EALL) && (mb == '0);
  assign zero_a = (ea == '0);
  assign zero_b = (eb == '0);

  logic [N-1:0]   sig_a, sig_b;
  logic [2*N-1:0] prod;
  assign sig_a = zero_a ? '0 : {1'b1, ma};
  assign sig_b = zero_b ? '0 : {1'b1, mb};

  csa_mult #(.N(N)) u_mult (
    .a   (sig_a),
    .b   (sig_b),
    .prod(prod)
  );

  // two nonzero normalized significands give a product in [1,4)
  always_comb begin
    if (!zero_a && !zero_b) begin
      a_prod_norm_r3: assert (prod[2*N-1] | prod[2*N-2]);
    end
  end

  logic [N-1:0]         sig_n;
  logic                 grd, stk;
  logic signed [EW-1:0] exp_p;

  always_comb begin
    exp_p = EW'(ea) + EW'(eb) - EW'(BIAS);
    if (prod[2*N-1]) begin
      sig_n = prod[2*N-1:N];
      grd   = prod[N-1];
      stk   = |prod[N-2:0];
      exp_p = exp_p + EW'(1);
    end else begin
      sig_n = prod[2*N-2:N-1];
      grd   = prod[N-2];
      stk   = |prod[N-3:0];
    end
  end

  logic [FW-1:0] rnd_res;

  fp_round #(.EXP_W(EXP_W), .MAN_W(MAN_W), .EW(EW)) u_rnd (
    .sign  (sp),
    .exp_in(exp_p),
    .sig_in(sig_n),
    .guard (grd),
    .sticky(stk),
    .res   (rnd_res)
  );

  always_comb begin
    if (nan_a || nan_b || (inf_a && zero_b) || (zero_a && inf_b))
      res = QNAN;
    else if (inf_a || inf_b)
      res = {sp, EALL, {MAN_W{1'b0}}};
    else if (zero_a || zero_b)
      res = {sp, {(FW-1){1'b0}}};
    else
      res = rnd_res;
  end

endmodule

// File: rtl/fp_unit.sv
module fp_unit
  import fpu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [4:0]      in_opcode,
  input  logic [XLEN-1:0] in_src1,
  input  logic [XLEN-1:0] in_src2,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result
);
  localparam int FW = 1 + EXP_W + MAN_W;
  localparam int EW = EXP_W + $clog2(MAN_W + 6) + 2;
  localparam logic [FW-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [FW-1:0] opa, opb, add_res, mul_res, sel_res, res_q;
  logic          is_add, is_sub, is_mul, is_fp, fire, vld_q;
  logic          hi_unused;

  assign opa       = in_src1[FW-1:0];
  assign opb       = in_src2[FW-1:0];
  assign hi_unused = ^{in_src1[XLEN-1:FW], in_src2[XLEN-1:FW]};

  assign is_add = (in_opcode == OPC_FADD);
  assign is_sub = (in_opcode == OPC_FSUB);
  assign is_mul = (in_opcode == OPC_FMUL);
  assign is_fp  = is_add | is_sub | is_mul;

  fp_add_core #(.EXP_W(EXP_W), .MAN_W(MAN_W), .EW(EW)) u_add (
    .a  (opa),
    .b  (opb),
    .sub(is_sub),
    .res(add_res)
  );

  fp_mul_core #(.EXP_W(EXP_W), .MAN_W(MAN_W), .EW(EW)) u_mul (
    .a  (opa),
    .b  (opb),
    .res(mul_res)
  );

  assign sel_res  = is_mul ? mul_res : add_res;
  assign in_ready = !vld_q || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (fire) begin
      vld_q <= is_fp;
      if (is_fp) res_q <= sel_res;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = {{(XLEN-FW){1'b0}}, res_q};

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && is_fp |=> out_valid);

  p_drop_other_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !is_fp |=> !out_valid);

  p_nan_canon_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (&out_result[FW-2:MAN_W]) && (|out_result[MAN_W-1:0])
      |-> out_result[FW-1:0] == QNAN);

endmodule

// File: tb/test_fp_unit.sv
`timescale 1ns/1ps
module test_fp_unit;
  localparam int XLEN = 16;
  localparam int EXP_W = 4;
  localparam int MAN_W = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [4:0]      in_opcode = 5'b0;
  logic [XLEN-1:0] in_src1 = '0;
  logic [XLEN-1:0] in_src2 = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [XLEN-1:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fp_unit #(.XLEN(XLEN), .EXP_W(EXP_W), .MAN_W(MAN_W)) i_fp_unit (
    .clk, .rst_n, .in_valid, .in_ready, .in_opcode, .in_src1, .in_src2,
    .out_valid, .out_ready, .out_result
  );

  task automatic check(bit ok, string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // opk: 0 add, 1 sub, 2 mul; 8-bit format, bias 7
  function automatic logic [7:0] fp_ref(int opk, logic [7:0] a, logic [7:0] b);
    logic sa, sb, s;
    int ea, eb, ma, mb, e, q, be;
    real va, vb, r, mag, frac, rem;
    bit nan_a, nan_b, inf_a, inf_b, zero_a, zero_b;
    sa = a[7]; sb = b[7] ^ (opk == 1);
    ea = int'(a[6:3]); eb = int'(b[6:3]);
    ma = int'(a[2:0]); mb = int'(b[2:0]);
    nan_a = (ea == 15) && (ma != 0); nan_b = (eb == 15) && (mb != 0);
    inf_a = (ea == 15) && (ma == 0); inf_b = (eb == 15) && (mb == 0);
    zero_a = (ea == 0); zero_b = (eb == 0);
    if (nan_a || nan_b) return 8'h7C;
    if (opk == 2) begin
      if ((inf_a && zero_b) || (zero_a && inf_b)) return 8'h7C;
      if (inf_a || inf_b) return {sa ^ b[7], 7'h78};
      if (zero_a || zero_b) return {sa ^ b[7], 7'h00};
    end else begin
      if (inf_a && inf_b) return (sa != sb) ? 8'h7C : {sa, 7'h78};
      if (inf_a) return {sa, 7'h78};
      if (inf_b) return {sb, 7'h78};
      if (zero_a && zero_b) return {sa & sb, 7'h00};
    end
    va = zero_a ? 0.0 : real'(8 + ma) * (2.0 ** (ea - 10));
    vb = zero_b ? 0.0 : real'(8 + mb) * (2.0 ** (eb - 10));
    if (sa) va = -va;
    if (sb) vb = -vb;
    r = (opk == 2) ? va * vb : va + vb;
    if (r == 0.0) return 8'h00;
    s = (r < 0.0);
    mag = s ? -r : r;
    e = 0;
    while (mag >= 2.0) begin mag = mag / 2.0; e++; end
    while (mag < 1.0) begin mag = mag * 2.0; e--; end
    frac = mag * 8.0;
    q = $rtoi(frac);
    rem = frac - real'(q);
    if (rem > 0.5 || (rem == 0.5 && (q % 2) == 1)) q++;
    if (q == 16) begin q = 8; e++; end
    be = e + 7;
    if (be >= 15) return {s, 7'h78};
    if (be <= 0) return {s, 7'h00};
    return {s, be[3:0], q[2:0]};
  endfunction

  function automatic string tag_of(int opk, logic [7:0] a, logic [7:0] b, logic [7:0] e);
    if ((a[6:3] == 4'hF && a[2:0] != 0) || (b[6:3] == 4'hF && b[2:0] != 0)) return "R4";
    if (e == 8'h7C) return "R5";
    if (e[6:0] == 7'h78) return "R6";
    if (a[6:3] == 4'h0 || b[6:3] == 4'h0) return "R7";
    if (e[6:0] == 7'h00) return (opk == 2) ? "R7" : "R8";
    return "R3";
  endfunction

  // drive at a falling edge, the result is registered at the next rising edge
  task automatic apply(logic [4:0] opc, int opk, logic [7:0] a, logic [7:0] b);
    logic [15:0] exp;
    in_valid  = 1'b1;
    in_opcode = opc;
    in_src1   = {a ^ 8'h5A, a};
    in_src2   = {b ^ 8'hA5, b};
    exp = {8'h00, fp_ref(opk, a, b)};
    @(negedge clk);
    check(out_valid && out_result == exp,
          $sformatf("R1/R2/%s", tag_of(opk, a, b, exp[7:0])),
          $sformatf("op=%0d a=%h b=%h", opk, a, b),
          {15'b0, out_valid, out_result}, {16'b1, exp});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9", "reset state",
          {30'b0, out_valid, in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R9, R10: back-pressure; 1.0 + 1.0 = 2.0 (0x40)
    out_ready = 1'b0;
    in_valid = 1'b1; in_opcode = 5'b00101;
    in_src1 = 16'hFF38; in_src2 = 16'h0038;
    @(negedge clk);
    check(out_valid && !in_ready && out_result == 16'h0040, "R9", "first accept under stall",
          {14'b0, out_valid, in_ready, out_result}, {16'h2, 16'h0040});
    in_opcode = 5'b00111; in_src1 = 16'h0040; in_src2 = 16'h0040;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid && out_result == 16'h0040, "R10", "held while stalled",
            {15'b0, out_valid, out_result}, {16'h1, 16'h0040});
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid && out_result == 16'h0048, "R9", "pending beat taken after stall (2*2=4)",
          {15'b0, out_valid, out_result}, {16'h1, 16'h0048});

    // R11: other codes consumed, no output
    in_opcode = 5'b00000;
    @(negedge clk);
    check(!out_valid && in_ready, "R11", "opcode 00000 drops",
          {30'b0, out_valid, in_ready}, 32'h1);
    in_opcode = 5'b01000;
    @(negedge clk);
    check(!out_valid, "R11", "opcode 01000 drops", {31'b0, out_valid}, 32'h0);
    in_valid = 1'b0; in_opcode = 5'b00101;
    @(negedge clk);
    check(!out_valid, "R9", "idle without valid", {31'b0, out_valid}, 32'h0);

    // exhaustive add and multiply, strided subtract
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(5'b00101, 0, a[7:0], b[7:0]);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(5'b00111, 2, a[7:0], b[7:0]);
    for (int a = 0; a < 256; a++)
      for (int b = a % 4; b < 256; b += 4)
        apply(5'b00110, 1, a[7:0], b[7:0]);
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule